// File: doc/BRIEF.md
# Register-list transfer sequencer

This block carries out the multiple-register load and store instructions of a 32-bit processor. It takes one 16-bit instruction word and expands it into a series of single-word transfers between the general register file and a stack in memory. Each register named in an 8-bit list field costs one memory access through the stack pointer, which is general register 15, and one register-file access. When the list is used up, the block writes the final stack pointer back and pulses a completion strobe.

The register file and the memory sit outside the block. Each is reached through a request line that stays high until the matching grant comes back. Instruction bit 8 picks the lower or upper half of the sixteen registers. Bit 9 separates stores from loads, and it also reverses how list bits map to registers. A store therefore pushes registers from the top of the half downward, and a load pops them in the opposite order.

Top module: `regListSeq`

## Requirements
- R1: A word is accepted only when its bits 15:10 equal 6'b100011, which covers the upper bytes 0x8C to 0x8F. Any other word leaves instrReady high, makes no register or memory request and raises no done.
- R2: Instruction bit 8 selects the registers: 0 selects R0 to R7 and 1 selects R8 to R15.
- R3: List bits are handled from bit 0 upward, one register per set bit. If bit 9 is 0, list bit i names register base+i. If bit 9 is 1, it names register base+7-i.
- R4: Register 15 is read first to load the stack pointer. After the last listed transfer, the final stack pointer is written to register 15, and that write also overrides a value just loaded into register 15.
- R5: With bit 9 set (store), each listed register is read and its value is written to memory at SP-4, after which SP becomes SP-4.
- R6: With bit 9 clear (load), memory at SP is read and written to the listed register, after which SP becomes SP+4.
- R7: An all-zero list raises done in the cycle after acceptance and makes no register or memory request.
- R8: instrReady is high only while the sequencer is idle. An instruction offered while it is busy is ignored.
- R9: The two low bits of memAddr are always zero.
- R10: At most one of regReq and memReq is high. A request that has not been granted holds its index, address and direction into the next cycle.
- R11: done is a one-cycle pulse followed by idle. With both grants held high, a list with n set bits raises done 2n+3 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | An instruction word is offered |
| instrWord | input | 16 | Instruction word |
| instrReady | output | 1 | Sequencer idle; a matching word is taken at this edge |
| done | output | 1 | One-cycle completion pulse |
| regReq | output | 1 | Register-file access request |
| regWe | output | 1 | Register-file write (1) or read (0) |
| regIdx | output | 4 | Register number |
| regWdata | output | 32 | Register write data |
| regRdata | input | 32 | Register read data, valid with the grant |
| regGnt | input | 1 | Register access granted this cycle |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | 32 | Word-aligned byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with the grant |
| memGnt | input | 1 | Memory access granted this cycle |

## Verification
Two events can fall on one grant edge: removing the last set list bit and stepping the stack pointer. The same edge also decides whether the next cycle starts another transfer or the write-back to register 15. Lists whose last bit selects register 15 itself put this collision under the most strain. The bench sweeps every list value with all four opcodes, once with grants held high and once with random stalls. It judges each run against the logged order of register indices, the final register file and memory contents, the count of memory accesses and the cycle of done. A second instruction offered while the sequencer is busy is provoked on one run and must leave no trace.

// File: rtl/regListPkg.sv
package regListPkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SPRD, ST_XA, ST_XB, ST_SPWR, ST_FIN
  } seqState_t;

  typedef struct packed {
    logic accept;   // latch instruction fields
    logic spLoad;   // capture stack pointer from register read
    logic spStep;   // advance stack pointer, retire lowest list bit
    logic dataCap;  // capture transfer word
    logic spPort;   // register port addresses the stack pointer
  } seqStrobe_t;
endpackage

// File: rtl/regListCtrl.sv
module regListCtrl
  import regListPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrValid,
  input  logic       opMatch,
  input  logic       newListZero,
  input  logic       isStore,
  input  logic       lastBit,
  input  logic       regGnt,
  input  logic       memGnt,
  output logic       instrReady,
  output logic       done,
  output logic       regReq,
  output logic       regWe,
  output logic       memReq,
  output logic       memWe,
  output seqStrobe_t stb
);
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState  = state;
    stb        = '0;
    instrReady = 1'b0;
    done       = 1'b0;
    regReq     = 1'b0;
    regWe      = 1'b0;
    memReq     = 1'b0;
    memWe      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        instrReady = 1'b1;
        if (instrValid && opMatch) begin
          stb.accept = 1'b1;
          nextState  = newListZero ? ST_FIN : ST_SPRD;
        end
      end
      ST_SPRD: begin
        regReq     = 1'b1;
        stb.spPort = 1'b1;
        if (regGnt) begin
          stb.spLoad = 1'b1;
          nextState  = ST_XA;
        end
      end
      ST_XA: begin
        regReq = isStore;
        memReq = !isStore;
        if (isStore ? regGnt : memGnt) begin
          stb.dataCap = 1'b1;
          nextState   = ST_XB;
        end
      end
      ST_XB: begin
        memReq = isStore;
        memWe  = isStore;
        regReq = !isStore;
        regWe  = !isStore;
        if (isStore ? memGnt : regGnt) begin
          stb.spStep = 1'b1;
          nextState  = lastBit ? ST_SPWR : ST_XA;
        end
      end
      ST_SPWR: begin
        regReq     = 1'b1;
        regWe      = 1'b1;
        stb.spPort = 1'b1;
        if (regGnt) nextState = ST_FIN;
      end
      ST_FIN: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/regListPath.sv
module regListPath
  import regListPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LIST_W = 8,
  parameter int IDX_W  = 4,
  parameter int INSTR_W = 16,
  parameter int SP_IDX = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         stb,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [DATA_W-1:0]  regRdata,
  input  logic [DATA_W-1:0]  memRdata,
  output logic               opMatch,
  output logic               newListZero,
  output logic               isStore,
  output logic               lastBit,
  output logic [IDX_W-1:0]   regIdx,
  output logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata
);
  localparam int POS_W  = $clog2(LIST_W);
  localparam int BYTE_W = DATA_W / 8;
  localparam int ALN_W  = $clog2(BYTE_W);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(BYTE_W);

  logic [LIST_W-1:0] listBits;
  logic              bankSel;
  logic              storeMode;
  logic [DATA_W-1:0] sp;
  logic [DATA_W-1:0] dataHold;
  logic [POS_W-1:0]  curPos;
  logic [POS_W-1:0]  listPos;
  logic [DATA_W-1:0] rawAddr;

  assign opMatch     = instrWord[15:10] == 6'b100011;
  assign newListZero = instrWord[LIST_W-1:0] == '0;
  assign isStore     = storeMode;
  assign lastBit     = (listBits & (listBits - 1'b1)) == '0;

  always_comb begin
    curPos = '0;
    for (int k = LIST_W - 1; k >= 0; k--)
      if (listBits[k]) curPos = POS_W'(k);
  end

  assign listPos  = storeMode ? POS_W'(LIST_W - 1) - curPos : curPos;
  assign regIdx   = stb.spPort ? IDX_W'(SP_IDX) : IDX_W'({bankSel, listPos});
  assign regWdata = stb.spPort ? sp : dataHold;
  assign rawAddr  = storeMode ? sp - STEP : sp;
  assign memAddr  = {rawAddr[DATA_W-1:ALN_W], {ALN_W{1'b0}}};
  assign memWdata = dataHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      listBits  <= '0;
      bankSel   <= 1'b0;
      storeMode <= 1'b0;
      sp        <= '0;
      dataHold  <= '0;
    end else begin
      if (stb.accept) begin
        listBits  <= instrWord[LIST_W-1:0];
        bankSel   <= instrWord[LIST_W];
        storeMode <= instrWord[LIST_W+1];
      end
      if (stb.spLoad) sp <= regRdata;
      if (stb.dataCap) dataHold <= storeMode ? regRdata : memRdata;
      if (stb.spStep) begin
        sp       <= storeMode ? sp - STEP : sp + STEP;
        listBits <= listBits & (listBits - 1'b1);
      end
    end
  end
endmodule

// File: rtl/regListSeq.sv
module regListSeq
  import regListPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LIST_W  = 8,
  parameter int IDX_W   = 4,
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output logic               instrReady,
  output logic               done,
  output logic               regReq,
  output logic               regWe,
  output logic [IDX_W-1:0]   regIdx,
  output logic [DATA_W-1:0]  regWdata,
  input  logic [DATA_W-1:0]  regRdata,
  input  logic               regGnt,
  output logic               memReq,
  output logic               memWe,
  output logic [DATA_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  input  logic [DATA_W-1:0]  memRdata,
  input  logic               memGnt
);
  seqStrobe_t stb;
  logic opMatch, newListZero, isStore, lastBit;

  regListCtrl uCtrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .opMatch(opMatch),
    .newListZero(newListZero), .isStore(isStore), .lastBit(lastBit),
    .regGnt(regGnt), .memGnt(memGnt), .instrReady(instrReady), .done(done),
    .regReq(regReq), .regWe(regWe), .memReq(memReq), .memWe(memWe), .stb(stb)
  );

  regListPath #(
    .DATA_W(DATA_W), .LIST_W(LIST_W), .IDX_W(IDX_W), .INSTR_W(INSTR_W),
    .SP_IDX((1 << IDX_W) - 1)
  ) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .instrWord(instrWord),
    .regRdata(regRdata), .memRdata(memRdata), .opMatch(opMatch),
    .newListZero(newListZero), .isStore(isStore), .lastBit(lastBit),
    .regIdx(regIdx), .regWdata(regWdata), .memAddr(memAddr), .memWdata(memWdata)
  );
endmodule

// File: rtl/regListChk.sv
module regListChk #(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 4,
  parameter int INSTR_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               instrValid,
  input logic [INSTR_W-1:0] instrWord,
  input logic               instrReady,
  input logic               done,
  input logic               regReq,
  input logic               regWe,
  input logic [IDX_W-1:0]   regIdx,
  input logic               regGnt,
  input logic               memReq,
  input logic               memWe,
  input logic [DATA_W-1:0]  memAddr,
  input logic               memGnt
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    instrReady |-> (!regReq && !memReq)); // R8
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rstN)
    !(regReq && memReq)); // R10
  AST_MEM_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00)); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R10
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regGnt) |=> (regReq && $stable(regIdx) && $stable(regWe))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && instrReady)); // R11
  AST_ZERO_LIST: assert property (@(posedge clk) disable iff (!rstN)
    (instrReady && instrValid && instrWord[15:10] == 6'b100011 && instrWord[7:0] == 8'h00)
      |=> (done && !regReq && !memReq)); // R7
  AST_FOREIGN_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (instrReady && instrValid && instrWord[15:10] != 6'b100011) |=> instrReady); // R1
endmodule

bind regListSeq regListChk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .INSTR_W(INSTR_W)) uChk (
  .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
  .instrReady(instrReady), .done(done), .regReq(regReq), .regWe(regWe),
  .regIdx(regIdx), .regGnt(regGnt), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memGnt(memGnt)
);

// File: tb/tb_regListSeq.sv
module tb_regListSeq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic        instrReady, done;
  logic        regReq, regWe, memReq, memWe;
  logic [3:0]  regIdx;
  logic [31:0] regWdata, regRdata, memAddr, memWdata, memRdata;
  logic        regGnt = 1'b1;
  logic        memGnt = 1'b1;
  logic        stallMode = 1'b0;

  logic [31:0] regModel [0:15];
  logic [31:0] memModel [0:511];
  logic [31:0] expReg [0:15];
  logic [31:0] expMem [0:511];
  logic [3:0]  logIdx [0:15];
  logic [3:0]  expIdx [0:15];
  int          logN = 0;
  int          memCount = 0;
  int          checkCnt = 0;
  int          failCnt = 0;

  always #10 clk = ~clk;

  regListSeq dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .instrReady(instrReady), .done(done), .regReq(regReq), .regWe(regWe),
    .regIdx(regIdx), .regWdata(regWdata), .regRdata(regRdata), .regGnt(regGnt),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memGnt(memGnt)
  );

  assign regRdata = regModel[regIdx];
  assign memRdata = memModel[memAddr[10:2]];

  always @(negedge clk) begin
    regGnt <= stallMode ? 1'($urandom_range(0, 1)) : 1'b1;
    memGnt <= stallMode ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  always @(posedge clk) begin
    if (regReq && regGnt) begin
      if (regWe) regModel[regIdx] <= regWdata;
      if (logN < 16) logIdx[logN] <= regIdx;
      logN <= logN + 1;
    end
    if (memReq && memGnt) begin
      if (memWe) memModel[memAddr[10:2]] <= memWdata;
      memCount <= memCount + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runOne(input logic [1:0] op, input logic [7:0] listv, input bit poke);
    logic [31:0] sp;
    int n, lat, regBad, memBad, seqBad;
    logic [3:0] base, r;
    @(negedge clk);
    for (int i = 0; i < 16; i++) regModel[i] = $urandom;
    for (int i = 0; i < 512; i++) memModel[i] = $urandom;
    regModel[15] = op[1] ? 32'h0000_0200 : 32'h0000_0100;
    logN = 0;
    memCount = 0;
    for (int i = 0; i < 16; i++) expReg[i] = regModel[i];
    for (int i = 0; i < 512; i++) expMem[i] = memModel[i];
    // independent model of the instruction
    base = op[0] ? 4'd8 : 4'd0;
    sp = expReg[15];
    n = 0;
    if (listv != 0) begin expIdx[0] = 4'd15; n = 1; end
    for (int i = 0; i < 8; i++) begin
      if (listv[i]) begin
        r = op[1] ? base + 4'(7 - i) : base + 4'(i);
        expIdx[n] = r;
        n++;
        if (op[1]) begin
          sp = sp - 4;
          expMem[sp[10:2]] = expReg[r];
        end else begin
          expReg[r] = expMem[sp[10:2]];
          sp = sp + 4;
        end
      end
    end
    if (listv != 0) begin expIdx[n] = 4'd15; n++; expReg[15] = sp; end
    chk(instrReady, "R8", "ready before issue", 32'(instrReady), 32'd1);
    instrValid = 1'b1;
    instrWord = {6'b100011, op, listv};
    @(posedge clk);
    @(negedge clk);
    instrValid = 1'b0;
    lat = 1;
    while (!done && lat < 1000) begin
      if (poke) begin
        instrValid = 1'b1;
        instrWord = 16'h8C01;
        chk(!instrReady, "R8", "ready while busy", 32'(instrReady), 32'd0);
      end
      @(negedge clk);
      lat++;
    end
    instrValid = 1'b0;
    @(negedge clk);
    chk(!done && instrReady, "R11", "done pulse width", 32'(done), 32'd0);
    regBad = 0; memBad = 0; seqBad = 0;
    for (int i = 0; i < 16; i++) if (regModel[i] !== expReg[i]) regBad++;
    for (int i = 0; i < 512; i++) if (memModel[i] !== expMem[i]) memBad++;
    if (logN != n) seqBad = 1;
    else for (int i = 0; i < n; i++) if (logIdx[i] !== expIdx[i]) seqBad++;
    chk(seqBad == 0, "R3", $sformatf("register order op%0d list %h", op, listv),
        32'(logN), 32'(n));
    chk(regBad == 0, op[1] ? "R4" : "R6", $sformatf("register file op%0d list %h", op, listv),
        32'(regBad), 32'd0);
    chk(memBad == 0, op[1] ? "R5" : "R2", $sformatf("memory op%0d list %h", op, listv),
        32'(memBad), 32'd0);
    chk(memCount == $countones(listv), "R10", "memory access count",
        32'(memCount), 32'($countones(listv)));
    if (listv == 0)
      chk(lat == 1, "R7", "empty list latency", 32'(lat), 32'd1);
    else if (!stallMode)
      chk(lat == 2 * $countones(listv) + 3, "R11", "latency without stalls",
          32'(lat), 32'(2 * $countones(listv) + 3));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(instrReady && !done && !regReq && !memReq, "R8", "reset state",
        {28'd0, instrReady, done, regReq, memReq}, 32'h8);
    rstN = 1'b1;
    @(negedge clk);
    // foreign opcodes are not taken (R1)
    for (int k = 0; k < 4; k++) begin
      instrValid = 1'b1;
      instrWord = (k == 0) ? 16'h8B05 : (k == 1) ? 16'h9005 : (k == 2) ? 16'h0CFF : 16'h8805;
      logN = 0; memCount = 0;
      repeat (3) @(negedge clk);
      chk(instrReady && !done && logN == 0 && memCount == 0, "R1",
          $sformatf("foreign word %h", instrWord), 32'(logN + memCount), 32'd0);
    end
    instrValid = 1'b0;
    for (int s = 0; s < 2; s++) begin
      stallMode = 1'(s);
      for (int op = 0; op < 4; op++)
        for (int m = 0; m < 256; m++)
          runOne(2'(op), 8'(m), 1'b0);
    end
    stallMode = 1'b0;
    runOne(2'b11, 8'h81, 1'b1);  // R8 offered while busy
    runOne(2'b00, 8'h80, 1'b1);  // R8 load variant
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule